// File: doc/BRIEF.md
# Approximation-Aware Supply Step Controller

This block sits beside one processor core and chooses when the core's supply voltage moves by one step and when the transaction in flight has to be thrown away. Software opens a transaction with a start pulse, which also loads an error allowance for that run. Each timing-error event is flagged as approximatable or exact. Approximatable errors are tolerated until the allowance is used up. An exact error, or one approximatable error more than the allowance, requests an abort.

The controller scales the voltage by the history of commits. A long unbroken run of successful commits walks the supply down one step. An abort that comes too soon after the previous abort walks it back up one step. The step index is zero at nominal voltage and counts down-steps from there. A floor derived from the parameters stops the index at 70% of nominal. The step outputs are one-cycle pulses meant for a regulator sequencer. All pins are plain event and level signals with no back-pressure, so every event is acted on in the cycle it is presented.

Top module: `approx_vstep_ctrl`

## Requirements
- R1: After reset `vlevel_idx` is 0 (nominal) and `abort_req`, `step_up` and `step_down` are low.
- R2: An exact error (`err_valid`=1, `err_approx`=0) while a transaction is open makes `abort_req` high for exactly one cycle, in the cycle after the error is presented.
- R3: Approximatable errors inside an open transaction are ignored while their count stays at or below the allowance E. The error that makes the count E+1 raises `abort_req`. With E=0 the first approximatable error aborts.
- R4: `txn_start` loads E from `txn_budget` and clears the ignored-error count, also when a transaction is already open (a retry). Each transaction therefore uses its own E.
- R5: Errors and commits that arrive while no transaction is open have no effect on any output. An error presented together with `txn_start` is discarded. An abort closes the transaction.
- R6: When a commit makes the count of consecutive commits exceed HI_THRESH (default 100, so on the 101st), `step_down` pulses and the run count restarts from zero.
- R7: On an abort, `step_up` pulses if fewer than LO_THRESH (default 10) commits happened since the previous abort (or since reset). With exactly LO_THRESH or more, no pulse occurs.
- R8: An abort restarts the consecutive-commit run, so a down-step needs HI_THRESH+1 commits after the abort.
- R9: `vlevel_idx` never exceeds MAX_IDX = (100-FLOOR_PCT)*NOM_MV/(100*STEP_MV), which is 15 by default. A down request at MAX_IDX gives no pulse and no change.
- R10: An up request at index 0 gives no pulse and no change.
- R11: `step_up` and `step_down` are never high together. Each is high for single cycles only. In a pulse cycle `vlevel_idx` has moved by exactly one (down-step +1, up-step -1), and it never moves without a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Transaction (re)start pulse; loads the allowance |
| txn_budget | input | BUDGET_W | Ignored-error allowance E for the transaction being started |
| txn_commit | input | 1 | Commit pulse of the open transaction |
| err_valid | input | 1 | Timing-error event |
| err_approx | input | 1 | 1 when the erroring instruction may be approximated |
| abort_req | output | 1 | One-cycle request to roll back the open transaction |
| step_up | output | 1 | One-cycle request to raise the supply by one step |
| step_down | output | 1 | One-cycle request to lower the supply by one step |
| vlevel_idx | output | LVL_W | Current step index, 0 = nominal |

## Verification
The bench presses on the edges of each count. It checks the Eth and the (E+1)th approximatable error, including E=0. It checks the 100th and the 101st commit of a run, and an abort after exactly 9 and exactly 10 commits. An off-by-one compare would abort one error early or late, or step on the wrong commit. It retries with a different allowance to catch a counter that is not cleared or a budget that is not reloaded, and it drives errors and commits outside a transaction to catch a design that acts on them anyway. It also drives the index into both the floor and nominal: a design without saturation would wrap the index or emit a step pulse the regulator cannot honour.

// File: rtl/approx_vstep_pkg.sv
`timescale 1ns/1ps
package approx_vstep_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_dir_t;
endpackage

// File: rtl/vstep_err_budget.sv
`timescale 1ns/1ps
// Tracks the open transaction and its ignored-error allowance; decides aborts.
module vstep_err_budget #(
  parameter int BUDGET_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                txn_start,
  input  logic [BUDGET_W-1:0] txn_budget,
  input  logic                txn_commit,
  input  logic                err_valid,
  input  logic                err_approx,
  output logic                txn_active,
  output logic                abort_now,
  output logic                commit_ok,
  output logic                abort_req
);
  logic [BUDGET_W-1:0] budget_q;
  logic [BUDGET_W-1:0] ignored_q;

  // Error arriving with a start belongs to the discarded run.
  assign abort_now = txn_active && err_valid && !txn_start &&
                     (!err_approx || (ignored_q >= budget_q));
  assign commit_ok = txn_active && txn_commit && !txn_start && !abort_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txn_active <= 1'b0;
      budget_q   <= '0;
      ignored_q  <= '0;
      abort_req  <= 1'b0;
    end else begin
      abort_req <= abort_now;
      if (txn_start) begin
        txn_active <= 1'b1;
        budget_q   <= txn_budget;
        ignored_q  <= '0;
      end else if (abort_now || commit_ok) begin
        txn_active <= 1'b0;
      end else if (txn_active && err_valid && err_approx) begin
        ignored_q <= ignored_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vstep_commit_tracker.sv
`timescale 1ns/1ps
// Counts commit runs and commits since the last abort; requests steps.
module vstep_commit_tracker
  import approx_vstep_pkg::*;
#(
  parameter int HI_THRESH = 100,
  parameter int LO_THRESH = 10
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      commit_ok,
  input  logic      abort_now,
  output step_dir_t step_req
);
  localparam int RUN_W = $clog2(HI_THRESH + 2);
  localparam int SA_W  = $clog2(LO_THRESH + 1);

  logic [RUN_W-1:0] run_q;
  logic [SA_W-1:0]  since_abort_q;
  logic             run_full;
  logic             few_commits;

  assign run_full    = commit_ok && (run_q >= RUN_W'(HI_THRESH));
  assign few_commits = since_abort_q < SA_W'(LO_THRESH);

  always_comb begin
    step_req = STEP_NONE;
    if (abort_now) begin
      if (few_commits) step_req = STEP_UP;
    end else if (run_full) begin
      step_req = STEP_DOWN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q         <= '0;
      since_abort_q <= '0;
    end else if (abort_now) begin
      run_q         <= '0;
      since_abort_q <= '0;
    end else if (commit_ok) begin
      run_q <= run_full ? '0 : run_q + 1'b1;
      if (few_commits) since_abort_q <= since_abort_q + 1'b1;
    end
  end
endmodule

// File: rtl/vstep_level_reg.sv
`timescale 1ns/1ps
// Saturating step index with single-cycle step pulses.
module vstep_level_reg
  import approx_vstep_pkg::*;
#(
  parameter int MAX_IDX = 15,
  parameter int LVL_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_dir_t        step_req,
  output logic [LVL_W-1:0] level_q,
  output logic             up_q,
  output logic             down_q
);
  logic can_down;
  logic can_up;

  assign can_down = (step_req == STEP_DOWN) && (level_q < LVL_W'(MAX_IDX));
  assign can_up   = (step_req == STEP_UP)   && (level_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
      up_q    <= 1'b0;
      down_q  <= 1'b0;
    end else begin
      up_q   <= can_up;
      down_q <= can_down;
      if (can_down)    level_q <= level_q + 1'b1;
      else if (can_up) level_q <= level_q - 1'b1;
    end
  end
endmodule

// File: rtl/approx_vstep_ctrl.sv
`timescale 1ns/1ps
module approx_vstep_ctrl
  import approx_vstep_pkg::*;
#(
  parameter int BUDGET_W  = 8,
  parameter int HI_THRESH = 100,
  parameter int LO_THRESH = 10,
  parameter int NOM_MV    = 1000,
  parameter int STEP_MV   = 20,
  parameter int FLOOR_PCT = 70,
  localparam int MAX_IDX  = ((100 - FLOOR_PCT) * NOM_MV) / (100 * STEP_MV),
  localparam int LVL_W    = (MAX_IDX < 2) ? 1 : $clog2(MAX_IDX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                txn_start,
  input  logic [BUDGET_W-1:0] txn_budget,
  input  logic                txn_commit,
  input  logic                err_valid,
  input  logic                err_approx,
  output logic                abort_req,
  output logic                step_up,
  output logic                step_down,
  output logic [LVL_W-1:0]    vlevel_idx
);
  logic      txn_active;
  logic      abort_now;
  logic      commit_ok;
  step_dir_t step_req;

  vstep_err_budget #(.BUDGET_W(BUDGET_W)) u_budget (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_start  (txn_start),
    .txn_budget (txn_budget),
    .txn_commit (txn_commit),
    .err_valid  (err_valid),
    .err_approx (err_approx),
    .txn_active (txn_active),
    .abort_now  (abort_now),
    .commit_ok  (commit_ok),
    .abort_req  (abort_req)
  );

  vstep_commit_tracker #(.HI_THRESH(HI_THRESH), .LO_THRESH(LO_THRESH)) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_ok (commit_ok),
    .abort_now (abort_now),
    .step_req  (step_req)
  );

  vstep_level_reg #(.MAX_IDX(MAX_IDX), .LVL_W(LVL_W)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_req (step_req),
    .level_q  (vlevel_idx),
    .up_q     (step_up),
    .down_q   (step_down)
  );
endmodule

// File: rtl/approx_vstep_ctrl_chk.sv
`timescale 1ns/1ps
module approx_vstep_ctrl_chk #(
  parameter int LVL_W   = 4,
  parameter int MAX_IDX = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txn_start,
  input logic             err_valid,
  input logic             err_approx,
  input logic             txn_active,
  input logic             abort_req,
  input logic             step_up,
  input logic             step_down,
  input logic [LVL_W-1:0] vlevel_idx
);
  p_exact_err_aborts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_active && err_valid && !err_approx && !txn_start) |=> abort_req);

  p_abort_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req);

  p_up_only_on_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |-> abort_req);

  p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vlevel_idx <= LVL_W'(MAX_IDX));

  p_no_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_down));

  p_down_moves_r11: assert property (@(posedge clk) disable iff (!rst_n)
    step_down |-> (vlevel_idx == $past(vlevel_idx) + 1'b1));

  p_up_moves_r11: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |-> (vlevel_idx == $past(vlevel_idx) - 1'b1));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_down) |-> $stable(vlevel_idx));
endmodule

bind approx_vstep_ctrl approx_vstep_ctrl_chk #(.LVL_W(LVL_W), .MAX_IDX(MAX_IDX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .txn_start  (txn_start),
  .err_valid  (err_valid),
  .err_approx (err_approx),
  .txn_active (txn_active),
  .abort_req  (abort_req),
  .step_up    (step_up),
  .step_down  (step_down),
  .vlevel_idx (vlevel_idx)
);

// File: tb/approx_vstep_ctrl_test.sv
`timescale 1ns/1ps
module approx_vstep_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txn_start = 1'b0;
  logic [7:0] txn_budget = '0;
  logic       txn_commit = 1'b0;
  logic       err_valid = 1'b0;
  logic       err_approx = 1'b0;
  logic       abort_req, step_up, step_down;
  logic [3:0] vlevel_idx;

  int checks = 0;
  int fails  = 0;
  logic o_abort, o_up, o_down;
  logic [3:0] o_lvl;

  always #4 clk = ~clk;

  approx_vstep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_budget(txn_budget),
    .txn_commit(txn_commit), .err_valid(err_valid), .err_approx(err_approx),
    .abort_req(abort_req), .step_up(step_up), .step_down(step_down),
    .vlevel_idx(vlevel_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, capture just after the posedge, then idle.
  task automatic cyc(input logic s, input logic [7:0] b, input logic c,
                     input logic e, input logic a);
    @(negedge clk);
    txn_start = s; txn_budget = b; txn_commit = c; err_valid = e; err_approx = a;
    @(posedge clk);
    #1;
    o_abort = abort_req; o_up = step_up; o_down = step_down; o_lvl = vlevel_idx;
    txn_start = 0; txn_commit = 0; err_valid = 0; err_approx = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) cyc(0, 0, 0, 0, 0);
    rst_n = 1'b1;
  endtask

  // n committed transactions; counts step_down pulses seen
  task automatic commits(input int n, output int downs);
    downs = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 1, 0, 0);
      if (o_down) downs++;
    end
  endtask

  task automatic exact_abort(output logic up);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0);
    up = o_up;
  endtask

  task automatic t_reset();
    do_reset();
    cyc(0, 0, 0, 0, 0);
    chk(o_lvl == 0 && !o_abort && !o_up && !o_down, "R1 reset state", o_lvl, 0);
  endtask

  task automatic t_exact();
    do_reset();
    cyc(1, 8'd5, 0, 0, 0);
    cyc(0, 0, 0, 1, 0);
    chk(o_abort, "R2 exact error aborts", o_abort, 1);
    cyc(0, 0, 0, 0, 0);
    chk(!o_abort, "R2 abort is one cycle", o_abort, 0);
  endtask

  task automatic t_budget();
    int seen;
    do_reset();
    cyc(1, 8'd3, 0, 0, 0);
    seen = 0;
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0, 1, 1);
      if (o_abort) seen++;
    end
    chk(seen == 0, "R3 errors within budget ignored", seen, 0);
    cyc(0, 0, 0, 1, 1);
    chk(o_abort, "R3 error E+1 aborts", o_abort, 1);
    cyc(1, 8'd0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1);
    chk(o_abort, "R3 zero budget aborts at once", o_abort, 1);
  endtask

  task automatic t_reload();
    do_reset();
    cyc(1, 8'd1, 0, 0, 0);
    cyc(0, 0, 0, 1, 1);
    chk(!o_abort, "R4 first run within budget", o_abort, 0);
    cyc(1, 8'd2, 0, 0, 0);
    cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 0, 1, 1);
    chk(!o_abort, "R4 retry clears count and loads new E", o_abort, 0);
    cyc(0, 0, 0, 1, 1);
    chk(o_abort, "R4 new E enforced", o_abort, 1);
  endtask

  task automatic t_idle();
    int seen;
    int d;
    do_reset();
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 1, 0);
      if (o_abort) seen++;
    end
    chk(seen == 0, "R5 errors with no open transaction ignored", seen, 0);
    cyc(1, 8'd0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);
    chk(!o_abort, "R5 error with start discarded", o_abort, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    chk(!o_abort, "R5 closed after abort", o_abort, 0);
    d = 0;
    for (int i = 0; i < 120; i++) begin
      cyc(0, 0, 1, 0, 0);
      if (o_down) d++;
    end
    chk(d == 0 && o_lvl == 0, "R5 commits outside transaction ignored", d, 0);
  endtask

  task automatic t_down_run();
    int d;
    do_reset();
    commits(100, d);
    chk(d == 0 && o_lvl == 0, "R6 no step at 100 commits", d, 0);
    commits(1, d);
    chk(d == 1 && o_lvl == 1, "R6 step down on commit 101", o_lvl, 1);
    commits(100, d);
    chk(d == 0 && o_lvl == 1, "R6 run restarts after step", o_lvl, 1);
    commits(1, d);
    chk(d == 1 && o_lvl == 2, "R6 second step", o_lvl, 2);
  endtask

  task automatic t_up_rules();
    int d;
    logic up;
    do_reset();
    commits(60, d);
    exact_abort(up);
    commits(100, d);
    chk(d == 0, "R8 abort restarts commit run", d, 0);
    commits(1, d);
    chk(d == 1 && o_lvl == 1, "R8 step after 101 post-abort commits", o_lvl, 1);
    exact_abort(up);
    chk(!up && o_lvl == 1, "R7 no up after many commits", o_lvl, 1);
    commits(10, d);
    exact_abort(up);
    chk(!up && o_lvl == 1, "R7 no up at exactly LO commits", o_lvl, 1);
    commits(9, d);
    exact_abort(up);
    chk(up && o_lvl == 0, "R7 up after 9 commits", o_lvl, 0);
    cyc(0, 0, 0, 0, 0);
    chk(!o_up, "R11 up pulse single cycle", o_up, 0);
    exact_abort(up);
    chk(!up && o_lvl == 0, "R10 no up at nominal", o_lvl, 0);
  endtask

  task automatic t_floor();
    int d;
    do_reset();
    commits(101 * 15, d);
    chk(d == 15 && o_lvl == 15, "R9 reaches floor index", o_lvl, 15);
    commits(101, d);
    chk(d == 0 && o_lvl == 15, "R9 held at floor", d, 0);
  endtask

  initial begin
    #1_200_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_exact();
    t_budget();
    t_reload();
    t_idle();
    t_down_run();
    t_up_rules();
    t_floor();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule